// File: doc/BRIEF.md
# Steerable Tick Watchdog

This block is a watchdog counter driven by a slow time base. The host writes one 8-bit setup byte. Two of its fields set the timeout: a 5-bit multiplier M and a 2-bit resolution R. The timeout is M × 4^R periods of an external 16 Hz strobe, so each period is 1/16 second. Writing the setup byte, or reading the status flag, restarts the countdown from the full timeout.

When the countdown runs out, the block sets a sticky expiry flag. The steering bit of the setup byte then decides what happens next. If the bit is clear, the block emits a one-cycle interrupt pulse. If the bit is set, the block emits a one-cycle reset request and wipes the setup byte to zero, which disarms the watchdog. The system that owns the reset pin uses that request, and it also clears the century-style companion bit kept in another register. A multiplier of zero disables the watchdog completely.

The time base and the system reset logic sit outside the block. The host keeps the timer alive by writing the setup byte or reading the flag within each timeout window.

Top module: `wdog_steer`

## Requirements
- R1: After reset, `cfg_q` is 0x00 and `exp_flag`, `irq_pulse` and `rst_req` are all 0.
- R2: A `cfg_we` cycle stores `cfg_wdata` into `cfg_q` for the next cycle. The byte is decoded as bits 1:0 = R, bits 6:2 = M and bit 7 = steering.
- R3: After a restart with M ≠ 0, expiry happens on the (M × 4^R)-th `tick` cycle that follows the restart cycle. Outputs change on the next clock edge.
- R4: A setup write restarts the countdown using the newly written value and clears `exp_flag` on the next clock edge.
- R5: A `flag_rd` cycle restarts the countdown using the stored `cfg_q` and clears `exp_flag` on the next clock edge.
- R6: Expiry sets `exp_flag`. The flag stays set until the next restart.
- R7: On expiry with the steering bit at 0, `irq_pulse` is high for exactly one cycle, `rst_req` stays low and `cfg_q` is unchanged.
- R8: On expiry with the steering bit at 1, `rst_req` is high for exactly one cycle, `irq_pulse` stays low and `cfg_q` becomes 0x00.
- R9: While M = 0, no expiry occurs no matter how many ticks arrive.
- R10: If a restart (write or flag read) falls in the same cycle as the final tick, the restart wins and no expiry occurs in that cycle.
- R11: After an expiry, further ticks cause no further expiry until a restart happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at 16 Hz |
| cfg_we | input | 1 | Setup byte write strobe |
| cfg_wdata | input | 8 | Setup byte write data |
| flag_rd | input | 1 | Status flag read strobe (restarts the timer) |
| cfg_q | output | 8 | Stored setup byte |
| exp_flag | output | 1 | Sticky expiry flag |
| irq_pulse | output | 1 | One-cycle interrupt on expiry when not steering |
| rst_req | output | 1 | One-cycle reset request on expiry when steering |

## Verification
The sharp corner is a restart and the final tick landing in the same cycle. In that case the restart must win: the flag stays clear, no pulse appears, and the count reloads. The bench provokes this on purpose in two ways. It issues a flag read together with the tick that would expire the timer, and it also throws random reads, writes and ticks at the block. A behavioural reference model, compared every cycle, decides whether the outcome is correct.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DEF_MULT_W = 5;
  localparam int DEF_RES_W  = 2;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_RST  = 2'd2
  } wd_act_e;
endpackage

// File: rtl/wdog_period.sv
module wdog_period #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = 11
) (
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic [CNT_W-1:0]  period
);
  localparam int STEPS = 1 << RES_W;

  logic [CNT_W-1:0] stage [STEPS];

  // each resolution step multiplies by four
  generate
    for (genvar i = 0; i < STEPS; i++) begin : g_step
      if (i == 0) begin : g_base
        assign stage[i] = CNT_W'(mult);
      end else begin : g_mul
        assign stage[i] = {stage[i-1][CNT_W-3:0], 2'b00};
      end
    end
  endgenerate

  assign period = stage[res];
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (kick) begin
      count <= load_val;
    end else if (tick && count != '0) begin
      count <= count - CNT_W'(1);
    end
  end

  assign expire = tick && !kick && (count == CNT_W'(1));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> count == $past(load_val));
  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !kick && count != '0) |=> count == $past(count) - CNT_W'(1));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !kick) |=> count == '0);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             flag_rd,
  input  logic             expire,
  output logic [CFG_W-1:0] cfg_q,
  output logic             exp_flag,
  output logic             irq_pulse,
  output logic             rst_req
);
  import wdog_pkg::*;

  wd_act_e act;
  logic    kick;

  assign kick = cfg_we || flag_rd;

  always_comb begin
    act = ACT_NONE;
    if (expire) act = cfg_q[CFG_W-1] ? ACT_RST : ACT_IRQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      exp_flag  <= 1'b0;
      irq_pulse <= 1'b0;
      rst_req   <= 1'b0;
    end else begin
      irq_pulse <= (act == ACT_IRQ);
      rst_req   <= (act == ACT_RST);
      if (cfg_we)              cfg_q <= cfg_wdata;
      else if (act == ACT_RST) cfg_q <= '0;
      if (kick)                exp_flag <= 1'b0;
      else if (act != ACT_NONE) exp_flag <= 1'b1;
    end
  end

  // R2
  store_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_q == $past(cfg_wdata));
  // R4
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> !exp_flag);
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  // R7
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_pulse && rst_req));
  // R8
  wipe_chk: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (cfg_q == '0 || $past(cfg_we)));
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(exp_flag) |-> (irq_pulse || rst_req));
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int MULT_W = wdog_pkg::DEF_MULT_W,
  parameter int RES_W  = wdog_pkg::DEF_RES_W,
  localparam int CFG_W = MULT_W + RES_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             flag_rd,
  output logic [CFG_W-1:0] cfg_q,
  output logic             exp_flag,
  output logic             irq_pulse,
  output logic             rst_req
);
  localparam int CNT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  logic [CFG_W-1:0] cfg_src;
  logic [CNT_W-1:0] load_val;
  logic             kick;
  logic             expire;

  assign kick    = cfg_we || flag_rd;
  assign cfg_src = cfg_we ? cfg_wdata : cfg_q;

  wdog_period #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) period_i (
    .mult   (cfg_src[RES_W +: MULT_W]),
    .res    (cfg_src[RES_W-1:0]),
    .period (load_val)
  );

  wdog_count #(.CNT_W(CNT_W)) count_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .kick     (kick),
    .load_val (load_val),
    .expire   (expire)
  );

  wdog_ctrl #(.CFG_W(CFG_W)) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .flag_rd   (flag_rd),
    .expire    (expire),
    .cfg_q     (cfg_q),
    .exp_flag  (exp_flag),
    .irq_pulse (irq_pulse),
    .rst_req   (rst_req)
  );

  // R9
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[RES_W +: MULT_W] == '0 && !cfg_we) |=> !(irq_pulse || rst_req));
  // R10
  kick_wins_chk: assert property (@(posedge clk) disable iff (rst)
    kick |=> !(irq_pulse || rst_req));
endmodule

// File: tb/wdog_steer_tb.sv
module wdog_steer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       flag_rd = 1'b0;
  logic [7:0] cfg_q;
  logic       exp_flag, irq_pulse, rst_req;

  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;
  int rst_cnt = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0;
  int m_cfg = 0;
  bit m_flag = 0, m_irq = 0, m_rst = 0;

  always #4 clk = ~clk;

  wdog_steer dut_i (
    .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flag_rd(flag_rd), .cfg_q(cfg_q), .exp_flag(exp_flag),
    .irq_pulse(irq_pulse), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, updated from inputs at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cfg = 0; m_flag = 0; m_irq = 0; m_rst = 0;
    end else begin
      bit kick, ex, st;
      int src, load;
      kick = cfg_we || flag_rd;
      src  = cfg_we ? int'(cfg_wdata) : m_cfg;
      load = ((src >> 2) & 31) * (4 ** (src & 3));
      ex   = !kick && tick && m_cnt == 1;
      st   = (m_cfg & 128) != 0;
      m_irq = ex && !st;
      m_rst = ex && st;
      if (cfg_we) m_cfg = cfg_wdata;
      else if (ex && st) m_cfg = 0;
      if (kick) m_cnt = load;
      else if (tick && m_cnt > 0) m_cnt = m_cnt - 1;
      if (kick) m_flag = 0;
      else if (ex) m_flag = 1;
    end
  end

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cfg_q == m_cfg[7:0], "R2 cfg_q", cfg_q, m_cfg);
      chk(exp_flag == m_flag, "R6 exp_flag", exp_flag, m_flag);
      chk(irq_pulse == m_irq, "R7 irq_pulse", irq_pulse, m_irq);
      chk(rst_req == m_rst, "R8 rst_req", rst_req, m_rst);
      if (irq_pulse) irq_cnt++;
      if (rst_req) rst_cnt++;
    end
  end

  task automatic step(input bit w, input logic [7:0] d, input bit r, input bit t);
    @(negedge clk);
    cfg_we = w; cfg_wdata = d; flag_rd = r; tick = t;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step(0, 8'h00, 0, 1);
      step(0, 8'h00, 0, 0);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int base;
    idle(3);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1
    chk(cfg_q == 0 && !exp_flag && !irq_pulse && !rst_req, "R1 reset state",
        {cfg_q, exp_flag, irq_pulse, rst_req}, 0);

    // M=3, R=1 -> 12 ticks, interrupt mode
    step(1, 8'h0D, 0, 0); idle(2);
    chk(cfg_q == 8'h0D, "R2 stored byte", cfg_q, 8'h0D);
    ticks(11); idle(2);
    chk(irq_cnt == 0 && !exp_flag, "R3 no expiry before 12th tick", irq_cnt, 0);
    ticks(1); idle(2);
    chk(irq_cnt == 1, "R3 expiry on 12th tick", irq_cnt, 1);
    chk(exp_flag == 1, "R6 flag set", exp_flag, 1);
    chk(cfg_q == 8'h0D && rst_cnt == 0, "R7 cfg kept, no reset", cfg_q, 8'h0D);
    ticks(20); idle(2);
    chk(irq_cnt == 1 && exp_flag, "R11 one shot", irq_cnt, 1);

    // flag read restart
    step(0, 8'h00, 1, 0); idle(2);
    chk(!exp_flag, "R5 read clears flag", exp_flag, 0);
    ticks(11); idle(2);
    chk(irq_cnt == 1, "R5 restart uses stored value (early)", irq_cnt, 1);
    ticks(1); idle(2);
    chk(irq_cnt == 2, "R5 restart uses stored value", irq_cnt, 2);

    // write restart mid-count
    step(1, 8'h0D, 0, 0); idle(1);
    chk(!exp_flag, "R4 write clears flag", exp_flag, 0);
    ticks(8);
    step(1, 8'h0D, 0, 0);
    ticks(11); idle(2);
    chk(irq_cnt == 2, "R4 write restarts count", irq_cnt, 2);
    ticks(1); idle(2);
    chk(irq_cnt == 3, "R4 expiry after rewrite", irq_cnt, 3);

    // restart on the final tick
    step(1, 8'h0D, 0, 0);
    ticks(11);
    step(0, 8'h00, 1, 1); idle(2);
    chk(irq_cnt == 3 && !exp_flag, "R10 read beats final tick", irq_cnt, 3);
    ticks(11); idle(2);
    chk(irq_cnt == 3, "R10 reload after collision", irq_cnt, 3);
    ticks(1); idle(2);
    chk(irq_cnt == 4, "R10 expiry after full reload", irq_cnt, 4);

    // disabled
    step(1, 8'h03, 0, 0);
    ticks(300); idle(2);
    chk(irq_cnt == 4 && rst_cnt == 0 && !exp_flag, "R9 M=0 never expires", irq_cnt, 4);

    // steering: M=2, R=2 -> 32 ticks
    step(1, 8'h8A, 0, 0);
    ticks(31); idle(2);
    chk(rst_cnt == 0, "R8 no request early", rst_cnt, 0);
    ticks(1); idle(2);
    chk(rst_cnt == 1 && irq_cnt == 4, "R8 reset request", rst_cnt, 1);
    chk(cfg_q == 8'h00, "R8 cfg wiped", cfg_q, 0);
    ticks(200); idle(2);
    chk(rst_cnt == 1, "R11 no repeat after wipe", rst_cnt, 1);

    // largest period: M=31, R=3 -> 1984 ticks
    step(1, 8'h7F, 0, 0);
    ticks(1983); idle(2);
    chk(irq_cnt == 4, "R3 max period early", irq_cnt, 4);
    ticks(1); idle(2);
    chk(irq_cnt == 5, "R3 max period", irq_cnt, 5);

    // random traffic compared against the model
    for (int i = 0; i < 20000; i++) begin
      bit w, r;
      w = ($urandom % 150) == 0;
      r = ($urandom % 200) == 0;
      step(w, 8'($urandom) & 8'h8F, r, ($urandom % 2) == 0);
    end
    idle(3);
    finish_run();
  end
endmodule